// File: doc/BRIEF.md
# Double-Buffered Dual-Mode PWM Channel

This block is one pulse-width modulator channel with a counter of its own. An external clock-select stage supplies a one-cycle tick, and the channel's counter moves only on clock cycles where that tick is high. The channel drives a single continuous waveform. That waveform can be edge-aligned, where the counter ramps up and wraps, or center-aligned, where the counter ramps up and then back down. A polarity bit chooses whether the duty part of the waveform is driven high or low.

Software writes period and duty values through a simple write-strobe port. These values go into shadow registers. They reach the active compare registers only when the counter finishes a full period and returns to zero, or on every cycle while the channel is disabled. A retuned waveform therefore never shows a partial, mixed period. The parameter `JOINED` sets the width of the counter and the value registers: 8 bits when it is 0, or 16 bits when it is 1, which stands for two narrow channels merged into one.

Top module: `dbuf_pwm_channel`

## Requirements
- R1: After a synchronous reset, the channel is disabled, polarity is 0, edge-aligned mode is selected, all period and duty registers hold 0, and `pwm_o` is 0.
- R2: In edge-aligned mode with active period P > 0, the counter goes 0, 1, …, P-1 and then wraps to 0, moving one step per tick, so one period lasts P ticks. A period of 0 holds the counter at 0.
- R3: In center-aligned mode with active period P > 0, the counter goes up from 0 to P and back down to 0, so one period lasts 2·P ticks.
- R4: The duty state holds while the counter is below the active duty D. If D = 0, the output stays at the non-duty level. If D ≥ P and D ≠ 0, the output stays at the duty level.
- R5: While the channel runs, writes to period and duty change only the shadow copies. The active values take the shadow values only at the tick that ends a period.
- R6: While the channel is disabled, the counter is held at 0, the active registers follow the shadow registers, and `pwm_o` rests at the non-duty level. When the channel is enabled again, it starts a new period from counter 0.
- R7: On cycles where `tick_i` is low, the counter and the waveform do not change.
- R8: Polarity bit 0 makes the duty level high and the non-duty level low. Polarity bit 1 swaps the two levels. Both levels follow immediately: `pwm_o` equals (enabled AND duty state) XOR polarity.
- R9: `wr_sel` selects the target of a write: 0 is the period shadow, 1 is the duty shadow, 2 is control, and 3 is ignored. In a control write, `wr_data` bit 0 is enable, bit 1 is polarity, and bit 2 selects center-aligned mode (1) or edge-aligned mode (0). A control write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Counter advance enable from the clock-select stage |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select (see R9) |
| wr_data | input | W (8 or 16) | Write data |
| pwm_o | output | 1 | Waveform output |

## Verification
The assertions assume that the alignment mode changes only while the channel is disabled. If the mode is switched while the channel runs, a count that is legal in one mode can sit outside the bounds checked for the other mode. The stimulus respects this: each mode change is part of a control write that also clears the enable bit, and the mode is then written again together with the enable bit. Enable and polarity are toggled freely while the channel runs. Period and duty are rewritten in the middle of a period, including writes that land on the cycle of the wrap tick.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        SEL_PER  = 2'd0,
        SEL_DTY  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Control word; packed MSB first so en lands on bit 0
    typedef struct packed {
        logic center;
        logic inv;
        logic en;
    } ctrl_t;

    localparam int CTRL_BITS = 3;

    function automatic int value_width(input bit joined);
        return joined ? 16 : 8;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output ctrl_t        ctrl,
    output logic [W-1:0] act_per,
    output logic [W-1:0] act_dty
);
    logic [W-1:0] sh_per, sh_dty;
    reg_sel_e     sel;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_per <= '0;
            sh_dty <= '0;
            ctrl   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_PER:  sh_per <= wr_data;
                SEL_DTY:  sh_dty <= wr_data;
                SEL_CTRL: ctrl   <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_per <= '0;
            act_dty <= '0;
        end else if (load) begin
            act_per <= sh_per;
            act_dty <= sh_dty;
        end
    end

    // R5: active values move only on a load
    p_hold_active_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(act_per) && $stable(act_dty)));
    p_copy_shadow_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (act_per == $past(sh_per) && act_dty == $past(sh_dty)));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         center,
    input  logic         tick,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         load
);
    logic down;
    logic left_wrap;
    logic ctr_end;

    assign left_wrap = (per == '0) || (cnt >= per - 1'b1);
    assign ctr_end   = down ? (cnt == {{(W-1){1'b0}}, 1'b1}) : (cnt >= per);
    assign load      = !en || (tick && (center ? ctr_end : left_wrap));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (tick) begin
            if (!center) begin
                down <= 1'b0;
                cnt  <= left_wrap ? '0 : cnt + 1'b1;
            end else if (!down) begin
                if (cnt < per) begin
                    cnt <= cnt + 1'b1;
                    if (cnt + 1'b1 == per) down <= 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
                if (cnt == {{(W-1){1'b0}}, 1'b1}) down <= 1'b0;
            end
        end
    end

    p_left_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !center && per != '0) |-> (cnt < per));
    p_center_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (en && center) |-> (cnt <= per));
    p_hold_notick_r7: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt));
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         inv,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per,
    input  logic [W-1:0] dty,
    output logic         pwm
);
    logic in_duty;

    assign in_duty = (dty != '0) && ((dty >= per) || (cnt < dty));
    assign pwm     = (en && in_duty) ^ inv;

    p_zero_duty_r4: assert property (@(posedge clk) disable iff (rst)
        (dty == '0) |-> (pwm == inv));
    p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
        (en && dty != '0 && dty >= per) |-> (pwm == !inv));
    p_rest_level_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |-> (pwm == inv));

endmodule

// File: rtl/dbuf_pwm_channel.sv
module dbuf_pwm_channel
    import pwm_pkg::*;
#(
    parameter bit JOINED = 1'b0,
    localparam int W = value_width(JOINED)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pwm_o
);
    ctrl_t        ctrl;
    logic [W-1:0] act_per, act_dty, cnt;
    logic         load;

    pwm_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (load),
        .ctrl    (ctrl),
        .act_per (act_per),
        .act_dty (act_dty)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (ctrl.en),
        .center (ctrl.center),
        .tick   (tick_i),
        .per    (act_per),
        .cnt    (cnt),
        .load   (load)
    );

    pwm_wave #(.W(W)) u_wave (
        .clk (clk),
        .rst (rst),
        .en  (ctrl.en),
        .inv (ctrl.inv),
        .cnt (cnt),
        .per (act_per),
        .dty (act_dty),
        .pwm (pwm_o)
    );

    p_reset_low_r1: assert property (@(posedge clk)
        $past(rst) |-> (pwm_o == 1'b0));

endmodule

// File: tb/tb_dbuf_pwm_channel.sv
module tb_dbuf_pwm_channel;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_i = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state
    int m_sp = 0, m_sd = 0, m_ap = 0, m_ad = 0, m_ph = 0;
    bit m_en = 0, m_inv = 0, m_c = 0;

    always #5 clk = ~clk;

    dbuf_pwm_channel dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pwm_o(pwm_o)
    );

    function automatic bit expect_out();
        int c;
        bit ds;
        if (m_c) c = (m_ph <= m_ap) ? m_ph : 2 * m_ap - m_ph;
        else     c = m_ph;
        ds = (m_ad != 0) && ((m_ad >= m_ap) || (c < m_ad));
        return (m_en && ds) ^ m_inv;
    endfunction

    task automatic check(input bit exp);
        n_run++;
        if (pwm_o !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_o=%0b expected %0b (per=%0d dty=%0d ph=%0d)",
                     tag, pwm_o, exp, m_ap, m_ad, m_ph);
        end
    endtask

    // called at a negedge: drive, advance model, wait one cycle, check
    task automatic step(input bit t, input bit we, input int sel, input int data);
        int len;
        tick_i  = t;
        wr_en   = we;
        wr_sel  = 2'(sel);
        wr_data = W'(data);
        if (!m_en) begin
            m_ap = m_sp; m_ad = m_sd; m_ph = 0;
        end else if (t) begin
            len = m_c ? 2 * m_ap : m_ap;
            if (len == 0) len = 1;
            if (m_ph + 1 >= len) begin
                m_ph = 0; m_ap = m_sp; m_ad = m_sd;
            end else begin
                m_ph++;
            end
        end
        if (we) begin
            case (sel)
                0: m_sp = data;
                1: m_sd = data;
                2: begin
                    m_en = data[0]; m_inv = data[1]; m_c = data[2];
                    if (!m_en) m_ph = 0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        check(expect_out());
    endtask

    task automatic wr(input int sel, input int data);
        step(1'b0, 1'b1, sel, data);
    endtask

    task automatic run(input int n, input int pat);
        for (int i = 0; i < n; i++)
            step((pat == 0) ? 1'b1 : ((i % pat) != pat - 1), 1'b0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int pers[5];
        pers = '{0, 1, 2, 3, 5};
        repeat (3) @(negedge clk);
        tag = "R1";
        check(1'b0);
        rst = 1'b0;
        @(negedge clk);
        check(1'b0);

        // sweep: mode, polarity, period, duty (R2, R3, R4, R8)
        for (int c = 0; c < 2; c++)
            for (int pv = 0; pv < 2; pv++)
                for (int k = 0; k < 5; k++)
                    for (int d = 0; d <= pers[k] + 1; d++) begin
                        int ctl;
                        ctl = (c << 2) | (pv << 1);
                        wr(2, ctl);
                        wr(0, pers[k]);
                        wr(1, d);
                        if (d == 0 || d >= pers[k]) tag = "R4";
                        else if (pv == 1) tag = "R8";
                        else tag = c ? "R3" : "R2";
                        wr(2, ctl | 1);
                        run(4 * pers[k] + 6, (d % 2 == 0) ? 0 : 3);
                    end

        // R7: tick held low, waveform frozen
        tag = "R7";
        wr(2, 0); wr(0, 6); wr(1, 3); wr(2, 1);
        run(4, 0);
        run(10, 1);
        run(8, 0);

        // R5: mid-period rewrites, edge-aligned then center-aligned
        for (int c = 0; c < 2; c++) begin
            tag = "R5";
            wr(2, 0); wr(0, 4); wr(1, 2); wr(2, (c << 2) | 1);
            run(2, 0);
            wr(0, 7); wr(1, 5);
            run(3, 0);
            wr(1, 1);
            run(20, 0);
            for (int i = 0; i < 12; i++) begin
                step(1'b1, 1'b1, i % 2, 2 + (i % 5));
            end
            run(20, 2);
        end

        // R6: disable mid-period, rest level, restart from zero
        tag = "R6";
        wr(2, 0); wr(0, 5); wr(1, 3); wr(2, 1);
        run(3, 0);
        wr(2, 0);
        run(6, 0);
        wr(0, 4); wr(1, 1);
        run(2, 0);
        wr(2, 1);
        run(10, 0);
        wr(2, 2 | 1);
        wr(2, 2);
        run(4, 0);
        wr(2, 3);
        run(10, 3);

        // R9: select 3 is ignored, control lands next cycle
        tag = "R9";
        wr(2, 0); wr(0, 6); wr(1, 2); wr(2, 1);
        run(3, 0);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 3, 8'hFF);
        run(8, 0);
        step(1'b1, 1'b1, 2, 3);
        run(8, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule